// File: doc/BRIEF.md
# CPU/DMA Bus Priority Arbiter

This block decides, cycle by cycle, which of two requesters (a processor and a DMA engine) owns a shared bus. Each side raises a request line and receives a grant line. A two-bit mode input selects the policy at run time: the processor always wins a contest, the DMA engine always wins, or the two take turns. One code point is reserved and is treated as processor-first.

Grants are registered. Requests and mode sampled on one rising edge set the grant seen after that edge. A one-bit rotation pointer records which side is favoured next. It is updated on every cycle in which a grant is issued, whatever the mode, so that a contested cycle in rotating mode always goes to the side that was not granted last.

Top module: `bus_prio_arbiter`

## Requirements
- R1: Synchronous active-low reset drives both grants low and sets the rotation pointer to favour the processor. The first contested cycle in rotating mode after reset is therefore granted to the processor.
- R2: With mode 2'b00 and both requests high, the processor is granted.
- R3: With mode 2'b11 and both requests high, the DMA engine is granted.
- R4: Mode 2'b10 is reserved and behaves exactly like 2'b00.
- R5: With mode 2'b01 and both requests high, the grant goes to the side not granted in the most recent granted cycle. A run of contested cycles alternates.
- R6: A lone request is granted in the next cycle in every mode.
- R7: When neither side requests, neither grant is high and the rotation pointer keeps its value.
- R8: At most one grant is high in any cycle.
- R9: The grant reflects the requests and mode sampled at the preceding rising edge. A new request does not show on a grant before that edge.
- R10: The rotation pointer is updated on grants issued in the fixed modes too. After a processor grant in mode 2'b00, a contested rotating cycle goes to the DMA engine.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prio_mode | input | 2 | Policy: 00 processor first, 01 rotate, 10 reserved (as 00), 11 DMA first |
| cpu_req | input | 1 | Processor bus request |
| dma_req | input | 1 | DMA engine bus request |
| cpu_gnt | output | 1 | Registered processor grant |
| dma_gnt | output | 1 | Registered DMA grant |

## Verification
The embedded assertions check the following on every cycle:
- mutual exclusion of the grants;
- the one-cycle grant for a lone requester;
- the empty grant when no side requests;
- the winner of a contest in each fixed mode;
- the winner of a contested rotating cycle, given the pointer value.

Some behaviours depend on history and are shown only by the bench's scenarios. These are the alternation over a run of rotating contests, the carry of the pointer from fixed-mode grants into rotating mode, the equivalence of the reserved code, and the pointer restart after a mid-run reset.

// File: rtl/bus_arb_pkg.sv
// Shared definitions for the two-requester bus arbiter.
// Assumes requester index 0 is the processor and index 1 the DMA engine.
package bus_arb_pkg;
    typedef enum logic [1:0] {
        PRIO_CPU      = 2'b00,
        PRIO_ROTATE   = 2'b01,
        PRIO_RESERVED = 2'b10,
        PRIO_DMA      = 2'b11
    } prio_mode_t;

    localparam int NUM_REQ = 2;
    localparam int IDX_CPU = 0;
    localparam int IDX_DMA = 1;
endpackage

// File: rtl/arb_favor_sel.sv
// Policy decode: turns the mode field and the rotation pointer into one
// bit that says whether the DMA side wins a contested cycle.
// Assumes the reserved code is handled as processor-first.
module arb_favor_sel
    import bus_arb_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       rot_favor_dma,
    output logic       favor_dma
);
    prio_mode_t mode_e;

    // Purpose: cast the raw field to the policy type.
    always_comb mode_e = prio_mode_t'(mode);

    // Purpose: choose the contest winner for the current policy.
    always_comb begin
        case (mode_e)
            PRIO_DMA:    favor_dma = 1'b1;
            PRIO_ROTATE: favor_dma = rot_favor_dma;
            default:     favor_dma = 1'b0;
        endcase
    end
endmodule

// File: rtl/arb_rotate_ptr.sv
// Rotation pointer: remembers which side to favour on the next contest.
// It flips towards the side not granted whenever any grant is issued.
// Assumes grant_next is one-hot or zero.
module arb_rotate_ptr
    import bus_arb_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant_next,
    output logic         favor_dma_q
);
    // Purpose: update the pointer after each grant and hold it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            favor_dma_q <= 1'b0;
        else if (grant_next[IDX_CPU])
            favor_dma_q <= 1'b1;
        else if (grant_next[IDX_DMA])
            favor_dma_q <= 1'b0;
    end
endmodule

// File: rtl/arb_grant_stage.sv
// Grant stage: picks a winner from the request vector and registers it.
// Assumes favor_dma is valid for the current requests.
module arb_grant_stage
    import bus_arb_pkg::*;
#(
    parameter int N = NUM_REQ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         favor_dma,
    output logic [N-1:0] grant_next,
    output logic [N-1:0] grant_q
);
    // Purpose: pick a single winner, using favor_dma only when both request.
    always_comb begin
        grant_next = '0;
        if (req[IDX_CPU] && req[IDX_DMA]) begin
            if (favor_dma) grant_next[IDX_DMA] = 1'b1;
            else           grant_next[IDX_CPU] = 1'b1;
        end else begin
            grant_next[IDX_CPU] = req[IDX_CPU];
            grant_next[IDX_DMA] = req[IDX_DMA];
        end
    end

    // Purpose: register the grant vector, clearing it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= '0;
        else        grant_q <= grant_next;
    end

    // R8
    grant_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));
endmodule

// File: rtl/bus_prio_arbiter.sv
// Top level: two-requester bus arbiter with a run-time selectable policy.
// Assumes requests are synchronous to clk. Grants appear one edge after
// the requests are sampled.
module bus_prio_arbiter
    import bus_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] prio_mode,
    input  logic       cpu_req,
    input  logic       dma_req,
    output logic       cpu_gnt,
    output logic       dma_gnt
);
    logic [NUM_REQ-1:0] req_vec;
    logic [NUM_REQ-1:0] grant_next;
    logic [NUM_REQ-1:0] grant_q;
    logic               rot_favor_dma;
    logic               favor_dma;

    // Purpose: gather the request lines into a vector.
    always_comb begin
        req_vec          = '0;
        req_vec[IDX_CPU] = cpu_req;
        req_vec[IDX_DMA] = dma_req;
    end

    arb_favor_sel u_favor (
        .mode          (prio_mode),
        .rot_favor_dma (rot_favor_dma),
        .favor_dma     (favor_dma)
    );

    arb_grant_stage #(.N(NUM_REQ)) u_grant (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req_vec),
        .favor_dma  (favor_dma),
        .grant_next (grant_next),
        .grant_q    (grant_q)
    );

    arb_rotate_ptr #(.N(NUM_REQ)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_next  (grant_next),
        .favor_dma_q (rot_favor_dma)
    );

    // Purpose: drive the output grant pins.
    always_comb begin
        cpu_gnt = grant_q[IDX_CPU];
        dma_gnt = grant_q[IDX_DMA];
    end

    // R6
    lone_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !dma_req) |=> (cpu_gnt && !dma_gnt));
    // R6
    lone_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !cpu_req) |=> (dma_gnt && !cpu_gnt));
    // R7
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_req && !dma_req) |=> (!cpu_gnt && !dma_gnt));
    // R2
    cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && prio_mode == 2'b00) |=> cpu_gnt);
    // R4
    reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && prio_mode == 2'b10) |=> cpu_gnt);
    // R3
    dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && prio_mode == 2'b11) |=> dma_gnt);
    // R5
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && dma_req && prio_mode == 2'b01) |=> (dma_gnt == $past(rot_favor_dma)));
endmodule

// File: tb/sim_bus_prio_arbiter.sv
`timescale 1ns/1ps
module sim_bus_prio_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] prio_mode;
    logic       cpu_req;
    logic       dma_req;
    logic       cpu_gnt;
    logic       dma_gnt;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    bus_prio_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .prio_mode(prio_mode),
        .cpu_req(cpu_req), .dma_req(dma_req),
        .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt)
    );

    // Vector layout: {mode[1:0], cpu_req, dma_req, exp_cpu, exp_dma}.
    // Applied in order right after reset, with the pointer favouring the processor.
    localparam int NVEC = 14;
    localparam logic [5:0] VECS [NVEC] = '{
        6'b00_11_10, // R2 contest, processor first
        6'b00_11_10, // R2 repeat
        6'b11_11_01, // R3 contest, DMA first
        6'b10_11_10, // R4 reserved acts as processor first
        6'b01_11_01, // R10 pointer set by the fixed-mode grant, so DMA wins
        6'b01_11_10, // R5 alternate
        6'b01_11_01, // R5 alternate
        6'b11_10_10, // R6 lone processor in DMA-first mode
        6'b00_01_01, // R6 lone DMA in processor-first mode
        6'b01_00_00, // R7 idle
        6'b01_11_10, // R7 pointer held through idle, processor wins
        6'b10_01_01, // R6 lone DMA in reserved mode
        6'b01_01_01, // R6 lone DMA in rotating mode
        6'b01_11_10  // R5 after a DMA grant, processor wins
    };

    task automatic check(input logic ec, input logic ed, input string tag);
        n_tests++;
        if (cpu_gnt !== ec || dma_gnt !== ed || (cpu_gnt && dma_gnt)) begin
            n_fail++;
            $display("FAIL %s: got cpu=%b dma=%b, expected cpu=%b dma=%b",
                     tag, cpu_gnt, dma_gnt, ec, ed);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic c, input logic d);
        @(negedge clk);
        prio_mode = m;
        cpu_req   = c;
        dma_req   = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        cpu_req = 1'b0;
        dma_req = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        prio_mode = 2'b00;
        cpu_req   = 1'b1;
        dma_req   = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check(1'b0, 1'b0, "R1 grants low in reset");
        @(negedge clk);
        rst_n   = 1'b1;
        cpu_req = 1'b0;
        dma_req = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][5:4], VECS[i][3], VECS[i][2]);
            check(VECS[i][1], VECS[i][0], $sformatf("vector %0d", i));
        end

        // R9: a request must not show on a grant before the next edge.
        apply(2'b00, 1'b0, 1'b0);
        @(negedge clk);
        prio_mode = 2'b00;
        cpu_req   = 1'b1;
        #1;
        check(1'b0, 1'b0, "R9 no grant before edge");
        @(posedge clk);
        #1;
        check(1'b1, 1'b0, "R9 grant after edge");

        // R1: a mid-run reset clears the pointer. The pointer favours DMA at
        // this point, after the processor grant above.
        do_reset();
        #1;
        check(1'b0, 1'b0, "R1 grants cleared by reset");
        apply(2'b01, 1'b1, 1'b1);
        check(1'b1, 1'b0, "R1 rotate restarts at processor");
        apply(2'b01, 1'b1, 1'b1);
        check(1'b0, 1'b1, "R5 second contest to DMA");

        // R10: a grant in DMA-first mode moves the pointer towards the processor.
        apply(2'b11, 1'b1, 1'b1);
        check(1'b0, 1'b1, "R3 DMA first");
        apply(2'b01, 1'b1, 1'b1);
        check(1'b1, 1'b0, "R10 pointer follows DMA-first grant");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule